// File: doc/BRIEF.md
# UART Interrupt Status and Line Fan-out

This block keeps the interrupt state of a UART. Eleven single-cycle set pulses arrive from the receive FIFO, the transmit data path, the receive timeout timer, the modem line detectors and the receive error detectors. Each pulse sets one bit of a raw status vector. A mask register selects which raw bits may raise an interrupt. Six level interrupt lines are driven from the masked vector. One line carries every source. The other five each carry one group: receive, transmit, timeout, modem and error.

Software uses a small word-addressed register port. It can read the raw, mask and masked vectors, write the mask, and clear raw bits by writing ones to a clear register. The receive FIFO logic can also clear the receive bit directly when a read drains the FIFO below its trigger level. Readback is combinational from the addressed register. All six interrupt outputs are registered together.

Top module: `uart_irq_hub`

## Requirements
- R1: While reset is held, and at the first edge after it is released, the raw vector, the mask and all six interrupt outputs are zero.
- R2: Status bit positions are: ring 0, clear-to-send 1, carrier 2, data-set-ready 3, receive 4, transmit 5, timeout 6, framing 7, parity 8, break 9, overrun 10. `modem_set[3:0]` feeds bits 3..0, `err_set[3:0]` feeds bits 10..7, and each pulse sets its bit at the next edge. Word offset 0 reads the raw vector in bits 10..0.
- R3: Word offset 1 is the read/write mask in bits 10..0. Word offset 2 reads raw AND mask. Bits above 10 always read as zero.
- R4: Writing word offset 3 clears each raw bit whose write-data bit is 1 and leaves the other raw bits unchanged. Offset 3 reads as zero.
- R5: When a set pulse and a clear of the same bit occur in the same cycle, the bit ends up set.
- R6: `rx_hit` sets bit 4. `rx_drain` clears bit 4. When both arrive in the same cycle, bit 4 ends up set.
- R7: Every `tx_wr` pulse sets bit 5, even if bit 5 is being cleared in that cycle.
- R8: Each output goes high when any bit of its group in the masked vector is set. The groups are: `irq_any` all bits, `irq_rx` bit 4, `irq_tx` bit 5, `irq_tmo` bit 6, `irq_modem` bits 3..0, `irq_err` bits 10..7.
- R9: All six outputs follow a change in raw status or mask exactly one clock later, and they change together.
- R10: Writes to offsets 0 and 2, and to offsets 4 and above, change no state. Offsets 4 and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| reg_addr | input | ADDR_W | Word address of the register port |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data of the addressed register |
| modem_set | input | 4 | Modem change pulses for bits 3..0 |
| rx_hit | input | 1 | Receive FIFO has reached its trigger level |
| rx_drain | input | 1 | A receive read has dropped the count below the trigger level |
| tx_wr | input | 1 | Transmit data register written |
| tmo_set | input | 1 | Receive timeout expired |
| err_set | input | 4 | Framing, parity, break and overrun pulses for bits 7..10 |
| irq_any | output | 1 | Interrupt from any masked source |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_tmo | output | 1 | Receive timeout interrupt |
| irq_modem | output | 1 | Modem status interrupt |
| irq_err | output | 1 | Receive error interrupt |

## Verification
The assertions take the set pulses as plain per-cycle levels. They assume the register port makes at most one write per cycle. Reset is held long enough for the registered outputs to settle to zero.

The bench drives every input at random at every cycle. This includes set pulses that collide with clear writes and `rx_drain`. The write address ranges over mapped and unmapped offsets, so the collision and ignored-write cases come up often as well as in directed runs. Set pulses and the write strobe are driven to zero while reset is held.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NB     = 11;
   localparam int NLINES = 6;
   localparam int B_RX   = 4;
   localparam int B_TX   = 5;
   localparam int B_TMO  = 6;

   typedef enum logic [1:0] {
      OFS_RAW    = 2'd0,
      OFS_MASK   = 2'd1,
      OFS_MASKED = 2'd2,
      OFS_CLEAR  = 2'd3
   } reg_ofs_e;

   // line order: any, rx, tx, timeout, modem, error
   localparam logic [NB-1:0] LINE_MASK [NLINES] = '{
      11'h7FF, 11'h010, 11'h020, 11'h040, 11'h00F, 11'h780
   };
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
   parameter int NB = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_vec,
   input  logic [NB-1:0] clr_vec,
   output logic [NB-1:0] raw_q
);
   initial begin
      if (NB < 1) $error("uart_irq_status: NB must be positive");
   end

   // set takes priority over clear for each bit
   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [NB-1:0]     wbits,
   input  logic [NB-1:0]     raw_q,
   output logic [NB-1:0]     mask_q,
   output logic [NB-1:0]     clr_bits,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD = DATA_W - NB;

   logic sel_mask, sel_clear;
   logic [NB-1:0] rd_bits;

   assign sel_mask  = (addr == ADDR_W'(OFS_MASK));
   assign sel_clear = (addr == ADDR_W'(OFS_CLEAR));

   always_ff @(posedge clk) begin
      if (!rst_n)               mask_q <= '0;
      else if (wr && sel_mask)  mask_q <= wbits;
   end

   assign clr_bits = (wr && sel_clear) ? wbits : '0;

   always_comb begin
      rd_bits = '0;
      if (addr == ADDR_W'(OFS_RAW))         rd_bits = raw_q;
      else if (sel_mask)                    rd_bits = mask_q;
      else if (addr == ADDR_W'(OFS_MASKED)) rd_bits = raw_q & mask_q;
   end

   assign rdata = {{PAD{1'b0}}, rd_bits};
endmodule

// File: rtl/uart_irq_fanout.sv
module uart_irq_fanout
   import uart_irq_pkg::*;
#(
   parameter bit REG_OUTPUTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NB-1:0]     masked,
   output logic [NLINES-1:0] lines
);
   logic [NLINES-1:0] hit;

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      assign hit[g] = |(masked & LINE_MASK[g]);
   end

   if (REG_OUTPUTS) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) lines <= '0;
         else        lines <= hit;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign lines = hit;
   end
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter bit REG_OUTPUTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [3:0]        modem_set,
   input  logic              rx_hit,
   input  logic              rx_drain,
   input  logic              tx_wr,
   input  logic              tmo_set,
   input  logic [3:0]        err_set,
   output logic              irq_any,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_tmo,
   output logic              irq_modem,
   output logic              irq_err
);
   initial begin
      if (ADDR_W < 2)  $error("uart_irq_hub: ADDR_W must be at least 2");
      if (DATA_W < 16) $error("uart_irq_hub: DATA_W must be at least 16");
   end

   logic [NB-1:0]     set_vec, clr_vec, clr_bits, raw_q, mask_q;
   logic [NLINES-1:0] lines;
   logic              unused_hi;

   assign unused_hi = ^reg_wdata[DATA_W-1:NB];

   assign set_vec = {err_set, tmo_set, tx_wr, rx_hit, modem_set};
   assign clr_vec = clr_bits | (NB'(rx_drain) << B_RX);

   uart_irq_status #(.NB(NB)) status_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .raw_q   (raw_q)
   );

   uart_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (reg_addr),
      .wr       (reg_wr),
      .wbits    (reg_wdata[NB-1:0]),
      .raw_q    (raw_q),
      .mask_q   (mask_q),
      .clr_bits (clr_bits),
      .rdata    (reg_rdata)
   );

   uart_irq_fanout #(.REG_OUTPUTS(REG_OUTPUTS)) fanout_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .masked (raw_q & mask_q),
      .lines  (lines)
   );

   assign irq_any   = lines[0];
   assign irq_rx    = lines[1];
   assign irq_tx    = lines[2];
   assign irq_tmo   = lines[3];
   assign irq_modem = lines[4];
   assign irq_err   = lines[5];
endmodule

// File: rtl/uart_irq_hub_chk.sv
module uart_irq_hub_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              rx_hit,
   input logic              rx_drain,
   input logic              tx_wr,
   input logic [10:0]       set_vec,
   input logic [10:0]       raw_q,
   input logic [10:0]       mask_q,
   input logic              irq_any,
   input logic              irq_rx,
   input logic              irq_tx,
   input logic              irq_modem,
   input logic              irq_err
);
   // R1: state is cleared by reset
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (raw_q == '0 && mask_q == '0));

   // R5: any set pulse wins over a clear
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

   // R4: clear write removes written bits not being set
   a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(3)) |=>
         ((raw_q & $past(reg_wdata[10:0]) & ~$past(set_vec)) == '0));

   // R6: drain without hit clears receive bit
   a_r6_rx_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_drain && !rx_hit) |=> !raw_q[4]);

   // R7: transmit write sets bit 5
   a_r7_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> raw_q[5]);

   // R9: outputs follow the masked vector one clock later
   a_r9_any_lag: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_any == |($past(raw_q & mask_q))));
   a_r9_rx_lag: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_rx == $past(raw_q[4] & mask_q[4])));

   // R8: grouped lines imply the combined line
   a_r8_groups_in_any: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_tx || irq_modem || irq_err || irq_rx) |-> irq_any);

   // R3: masked readback
   a_r3_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(2)) |-> (reg_rdata[10:0] == (raw_q & mask_q)
                                    && reg_rdata[DATA_W-1:11] == '0));

   // R10: with no set, no clear and no drain the raw vector holds
   a_r10_raw_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec == '0 && !rx_drain && !(reg_wr && reg_addr == ADDR_W'(3)))
         |=> $stable(raw_q));
endmodule

bind uart_irq_hub uart_irq_hub_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .rx_hit    (rx_hit),
   .rx_drain  (rx_drain),
   .tx_wr     (tx_wr),
   .set_vec   (set_vec),
   .raw_q     (raw_q),
   .mask_q    (mask_q),
   .irq_any   (irq_any),
   .irq_rx    (irq_rx),
   .irq_tx    (irq_tx),
   .irq_modem (irq_modem),
   .irq_err   (irq_err)
);

// File: tb/uart_irq_hub_tb_top.sv
module uart_irq_hub_tb_top;
   localparam int AW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [3:0]    modem_set = '0;
   logic          rx_hit = 1'b0, rx_drain = 1'b0, tx_wr = 1'b0, tmo_set = 1'b0;
   logic [3:0]    err_set = '0;
   logic irq_any, irq_rx, irq_tx, irq_tmo, irq_modem, irq_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [10:0] m_raw = '0, m_mask = '0;
   logic [5:0]  m_out = '0;

   always #5 clk = ~clk;

   uart_irq_hub #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .modem_set(modem_set),
      .rx_hit(rx_hit), .rx_drain(rx_drain), .tx_wr(tx_wr), .tmo_set(tmo_set),
      .err_set(err_set), .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx),
      .irq_tmo(irq_tmo), .irq_modem(irq_modem), .irq_err(irq_err));

   function automatic logic [5:0] groups(input logic [10:0] m);
      return {|m[10:7], |m[3:0], m[6], m[5], m[4], |m};
   endfunction

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      case (a)
         4'd0:    return DW'(m_raw);
         4'd1:    return DW'(m_mask);
         4'd2:    return DW'(m_raw & m_mask);
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      reg_wr = 1'b0; reg_wdata = '0; modem_set = '0; rx_hit = 1'b0;
      rx_drain = 1'b0; tx_wr = 1'b0; tmo_set = 1'b0; err_set = '0;
   endtask

   // one clock: update model from inputs held at the edge, then check outputs
   task automatic step(input string tag);
      logic [10:0] setv, clr;
      @(posedge clk);
      setv = {err_set, tmo_set, tx_wr, rx_hit, modem_set};
      clr = '0;
      if (reg_wr && reg_addr == 4'd3) clr = reg_wdata[10:0];
      if (rx_drain) clr[4] = 1'b1;
      m_out = groups(m_raw & m_mask);
      m_raw = (m_raw & ~clr) | setv;
      if (reg_wr && reg_addr == 4'd1) m_mask = reg_wdata[10:0];
      #1;
      chk(tag, DW'({irq_err, irq_modem, irq_tmo, irq_tx, irq_rx, irq_any}), DW'(m_out));
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      reg_wr = 1'b0;
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp_read(a));
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step("R9");
      idle_inputs();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4417));
      idle_inputs();
      repeat (3) @(posedge clk);
      #1;
      chk("R1", DW'({irq_err, irq_modem, irq_tmo, irq_tx, irq_rx, irq_any}), '0);
      rd(4'd0, "R1"); rd(4'd1, "R1");
      @(negedge clk); rst_n = 1'b1;
      step("R1");
      rd(4'd0, "R1");

      // R2 and R8: each source alone, mask open
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd1, "R3");
      for (int i = 0; i < 11; i++) begin
         if (i < 4)       modem_set[i] = 1'b1;
         else if (i == 4) rx_hit = 1'b1;
         else if (i == 5) tx_wr = 1'b1;
         else if (i == 6) tmo_set = 1'b1;
         else             err_set[i-7] = 1'b1;
         step("R2");
         idle_inputs();
         rd(4'd0, "R2");
         chk("R2", reg_rdata, DW'(1) << i);
         step("R8");
         wr(4'd3, 32'h7FF);
         rd(4'd0, "R4");
      end

      // R5 and R7: set colliding with clear
      tx_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 32'h7FF; reg_wr = 1'b1;
      step("R5"); idle_inputs();
      rd(4'd0, "R7");
      chk("R5", reg_rdata, 32'h020);

      // R6: hit and drain together, then drain alone
      rx_hit = 1'b1; rx_drain = 1'b1; step("R6"); idle_inputs();
      rd(4'd0, "R6");
      rx_drain = 1'b1; step("R6"); idle_inputs();
      rd(4'd0, "R6");
      chk("R6", reg_rdata, 32'h020);

      // R10: writes to read-only and unmapped offsets
      wr(4'd0, 32'hFFFF_FFFF); wr(4'd2, 32'h0); wr(4'd7, 32'hFFFF_FFFF);
      rd(4'd0, "R10"); rd(4'd1, "R10"); rd(4'd7, "R10"); rd(4'd3, "R4");

      // R9: mask closed then reopened, outputs lag by one clock
      wr(4'd1, 32'h0);
      step("R9");
      wr(4'd1, 32'h020);
      step("R9");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom;
         modem_set = (r[3:0] == 4'd0) ? r[7:4] : 4'd0;
         rx_hit = r[8] & r[9];
         rx_drain = r[10];
         tx_wr = r[11] & r[12];
         tmo_set = r[13] & r[14];
         err_set = (r[15:14] == 2'd0) ? r[19:16] : 4'd0;
         reg_wr = r[20];
         reg_addr = AW'(r[23:21] % 3'd6);
         reg_wdata = $urandom;
         step("R8");
         idle_inputs();
         r = $urandom;
         rd(AW'(r[2:0] % 3'd6), (r[2:0] == 3'd3) ? "R4" : "R3");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule